// File: doc/BRIEF.md
# Interrupt Mask and Acceptance Gate

This block keeps the two interrupt-mask flags of a processor's condition code register and decides, every clock cycle, whether an interrupt is accepted and from which source. One flag gates the ordinary maskable request line. The other gates a dedicated active-low nonmaskable pin. A software-interrupt strobe and an illegal-opcode trap strobe are always accepted, whatever the state of either flag.

The nonmaskable flag can only be cleared by software. Once it is clear, no software write and no return-from-interrupt restore can set it again. Only reset and acceptance of a pin interrupt set it. So after initialisation the pin becomes truly nonmaskable, and it can still not re-enter its own handler. The pin passes through a synchronizer and is treated as a level.

Each accepted interrupt produces a one-cycle take pulse and a 2-bit source code. The surrounding core uses these to fetch a vector and stack registers; those steps are not part of this block.

Top module: `irq_gate`

## Requirements
- R1: After reset the maskable flag and the nonmaskable flag both read 1, take_o is 0 and src_o is 0.
- R2: A high irq_req_i is accepted only while the maskable flag is 0. Acceptance shows as take_o=1 with src_o=3 on the cycle after the request is sampled.
- R3: The nonmaskable pin requests while low and is accepted only while the nonmaskable flag is 0. take_o=1 with src_o=2 appears SYNC_STAGES+1 clock edges after the pin is sampled low.
- R4: A software write may change the nonmaskable flag from 1 to 0, but a write of 1 while the flag is 0 is ignored.
- R5: A software write (wr_en_i) loads wr_imask_i into the maskable flag on the next edge.
- R6: Every acceptance sets the maskable flag on the same edge as the take pulse. Acceptance of the pin interrupt also sets the nonmaskable flag.
- R7: trap_i and swi_i are accepted regardless of either flag.
- R8: At most one source is accepted per cycle, in this order: trap (src 0), software interrupt (src 1), pin (src 2), maskable request (src 3).
- R9: A return strobe (rti_i) clears the maskable flag. It sets the nonmaskable flag to the AND of its old value and rti_xmask_i, so a restore never sets it.
- R10: take_o is high only on cycles that follow an accepted request. src_o holds its last value while take_o is low.
- R11: When an acceptance coincides with a return strobe or a software write, the acceptance's flag settings win. A return strobe takes precedence over a simultaneous software write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| xirq_n_i | input | 1 | Nonmaskable interrupt pin, active low, asynchronous |
| irq_req_i | input | 1 | Maskable interrupt request level |
| swi_i | input | 1 | Software-interrupt strobe |
| trap_i | input | 1 | Illegal-opcode trap strobe |
| wr_en_i | input | 1 | Software write of the mask flags |
| wr_imask_i | input | 1 | Value written to the maskable flag |
| wr_xmask_i | input | 1 | Value written to the nonmaskable flag (only a 0 has effect) |
| rti_i | input | 1 | Return-from-interrupt restore strobe |
| rti_xmask_i | input | 1 | Restored nonmaskable flag value |
| imask_o | output | 1 | Current maskable flag |
| xmask_o | output | 1 | Current nonmaskable flag |
| take_o | output | 1 | One-cycle interrupt acceptance pulse |
| src_o | output | 2 | Source code of the last accepted interrupt |

## Verification
The strobes, the maskable request, software writes and return strobes all reach take_o, src_o and both flags one edge after they are sampled. The pin needs SYNC_STAGES+1 edges. The bench drives every stimulus on a falling edge and reads the results on the next falling edge. For the pin it checks the cycles just before the expected edge as well, so that the latency is pinned exactly in both directions. The pin tests also cover the cycle after acceptance and the synchronizer flush after release, so a late or repeated take is caught.

// File: rtl/irq_gate_pkg.sv
package irq_gate_pkg;

    localparam int unsigned N_SRC = 4;
    localparam int unsigned SRC_W = $clog2(N_SRC);

    // lower code wins arbitration
    typedef enum logic [SRC_W-1:0] {
        SRC_TRAP     = 2'd0,
        SRC_SWI      = 2'd1,
        SRC_NMI      = 2'd2,
        SRC_MASKABLE = 2'd3
    } src_e;

    typedef struct packed {
        logic imask;
        logic xmask;
    } mask_t;

    typedef struct packed {
        logic take;
        src_e src;
    } take_t;

endpackage

// File: rtl/irq_gate_sync.sv
module irq_gate_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pin_n_i,
    output logic req_o
);

    logic [STAGES-1:0] sync_d, sync_q;

    always_comb begin
        sync_d = {sync_q[STAGES-2:0], pin_n_i};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '1;
        else         sync_q <= sync_d;
    end

    assign req_o = ~sync_q[STAGES-1];

    initial begin
        a_r3_stage_count : assert (STAGES >= 2);
    end

endmodule

// File: rtl/irq_gate_mask.sv
module irq_gate_mask
    import irq_gate_pkg::*;
(
    input  logic  clk_i,
    input  logic  rst_ni,
    input  logic  set_i_i,
    input  logic  set_x_i,
    input  logic  wr_en_i,
    input  logic  wr_imask_i,
    input  logic  wr_xmask_i,
    input  logic  rti_i,
    input  logic  rti_xmask_i,
    output mask_t mask_o
);

    mask_t mask_d, mask_q;

    always_comb begin
        mask_d = mask_q;
        if (rti_i) begin
            mask_d.imask = 1'b0;
            mask_d.xmask = mask_q.xmask & rti_xmask_i;
        end else if (wr_en_i) begin
            mask_d.imask = wr_imask_i;
            mask_d.xmask = mask_q.xmask & wr_xmask_i;
        end
        if (set_i_i) mask_d.imask = 1'b1;
        if (set_x_i) mask_d.xmask = 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) mask_q <= '{imask: 1'b1, xmask: 1'b1};
        else         mask_q <= mask_d;
    end

    assign mask_o = mask_q;

    // R4: only an accepted pin interrupt may raise the nonmaskable flag
    a_r4_xmask_rise_hw_only : assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(mask_q.xmask) |-> $past(set_x_i));

    // R9: a return without a coinciding acceptance leaves the maskable flag clear
    a_r9_rti_clears_imask : assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rti_i && !set_i_i) |=> !mask_q.imask);

endmodule

// File: rtl/irq_gate_arb.sv
module irq_gate_arb
    import irq_gate_pkg::*;
(
    input  logic  clk_i,
    input  logic  rst_ni,
    input  logic  trap_i,
    input  logic  swi_i,
    input  logic  nmi_req_i,
    input  logic  irq_req_i,
    input  mask_t mask_i,
    output logic  set_i_o,
    output logic  set_x_o,
    output take_t take_o
);

    logic [N_SRC-1:0] req;
    src_e             win;
    logic             grant;
    take_t            take_d, take_q;

    always_comb begin
        req               = '0;
        req[SRC_TRAP]     = trap_i;
        req[SRC_SWI]      = swi_i;
        req[SRC_NMI]      = nmi_req_i & ~mask_i.xmask;
        req[SRC_MASKABLE] = irq_req_i & ~mask_i.imask;
        grant             = |req;
        win               = SRC_MASKABLE;
        for (int k = N_SRC - 1; k >= 0; k--) begin
            if (req[k]) win = src_e'(k[SRC_W-1:0]);
        end
        take_d.take = grant;
        take_d.src  = grant ? win : take_q.src;
        set_i_o     = grant;
        set_x_o     = grant && (win == SRC_NMI);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) take_q <= '{take: 1'b0, src: SRC_TRAP};
        else         take_q <= take_d;
    end

    assign take_o = take_q;

    // R8: a trap strobe always wins the arbitration
    a_r8_trap_first : assert property (@(posedge clk_i) disable iff (!rst_ni)
        trap_i |=> (take_q.take && take_q.src == SRC_TRAP));

endmodule

// File: rtl/irq_gate.sv
module irq_gate
    import irq_gate_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             xirq_n_i,
    input  logic             irq_req_i,
    input  logic             swi_i,
    input  logic             trap_i,
    input  logic             wr_en_i,
    input  logic             wr_imask_i,
    input  logic             wr_xmask_i,
    input  logic             rti_i,
    input  logic             rti_xmask_i,
    output logic             imask_o,
    output logic             xmask_o,
    output logic             take_o,
    output logic [SRC_W-1:0] src_o
);

    logic  nmi_req;
    logic  set_i, set_x;
    mask_t mask;
    take_t take;

    irq_gate_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .pin_n_i (xirq_n_i),
        .req_o   (nmi_req)
    );

    irq_gate_arb i_arb (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .trap_i    (trap_i),
        .swi_i     (swi_i),
        .nmi_req_i (nmi_req),
        .irq_req_i (irq_req_i),
        .mask_i    (mask),
        .set_i_o   (set_i),
        .set_x_o   (set_x),
        .take_o    (take)
    );

    irq_gate_mask i_mask (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .set_i_i     (set_i),
        .set_x_i     (set_x),
        .wr_en_i     (wr_en_i),
        .wr_imask_i  (wr_imask_i),
        .wr_xmask_i  (wr_xmask_i),
        .rti_i       (rti_i),
        .rti_xmask_i (rti_xmask_i),
        .mask_o      (mask)
    );

    assign imask_o = mask.imask;
    assign xmask_o = mask.xmask;
    assign take_o  = take.take;
    assign src_o   = take.src;

    // R6: the maskable flag is set whenever a take pulse is out
    a_r6_take_sets_imask : assert property (@(posedge clk_i) disable iff (!rst_ni)
        take_o |-> imask_o);

    // R2: maskable acceptance only from a clear maskable flag
    a_r2_maskable_gated : assert property (@(posedge clk_i) disable iff (!rst_ni)
        (take_o && src_o == SRC_MASKABLE) |-> $past(!imask_o));

    // R3: pin acceptance only from a clear nonmaskable flag, which it then sets
    a_r3_nmi_gated : assert property (@(posedge clk_i) disable iff (!rst_ni)
        (take_o && src_o == SRC_NMI) |-> ($past(!xmask_o) && xmask_o));

    // R7: a software interrupt without a trap is always accepted
    a_r7_swi_unmasked : assert property (@(posedge clk_i) disable iff (!rst_ni)
        (swi_i && !trap_i) |=> (take_o && src_o == SRC_SWI));

    // R10: source code only moves together with a take pulse
    a_r10_src_holds : assert property (@(posedge clk_i) disable iff (!rst_ni)
        !take_o |-> $stable(src_o));

endmodule

// File: tb/test_irq_gate.sv
module test_irq_gate;
    import irq_gate_pkg::*;

    localparam int unsigned SYNC = 2;
    localparam int unsigned NVEC = 15;

    logic clk = 1'b0;
    logic rst_ni = 1'b0;
    logic xirq_n = 1'b1, irq_req = 1'b0, swi = 1'b0, trap = 1'b0;
    logic wr_en = 1'b0, wr_i = 1'b0, wr_x = 1'b0, rti = 1'b0, rti_x = 1'b0;
    logic imask, xmask, take;
    logic [SRC_W-1:0] src;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    irq_gate #(.SYNC_STAGES(SYNC)) i_irq_gate (
        .clk_i(clk), .rst_ni(rst_ni), .xirq_n_i(xirq_n), .irq_req_i(irq_req),
        .swi_i(swi), .trap_i(trap), .wr_en_i(wr_en), .wr_imask_i(wr_i),
        .wr_xmask_i(wr_x), .rti_i(rti), .rti_xmask_i(rti_x),
        .imask_o(imask), .xmask_o(xmask), .take_o(take), .src_o(src)
    );

    // bits: wr wi wx rti | rx trap swi irq | take src1 src0 imask | xmask 000
    localparam logic [15:0] VEC [NVEC] = '{
        16'b0000_0001_0001_1000, // R2 request blocked by reset mask
        16'b1010_0000_0000_1000, // R5 clear maskable flag, x write 1 keeps 1
        16'b0000_0001_1111_1000, // R2 R6 maskable accepted, src 3
        16'b0000_0001_0001_1000, // R2 blocked again after acceptance
        16'b0000_0100_1001_1000, // R7 trap while both masked
        16'b0000_0010_1011_1000, // R7 software interrupt while masked
        16'b0000_0111_1001_1000, // R8 trap beats swi and irq
        16'b1000_0000_0000_0000, // R4 software clears nonmaskable flag
        16'b1010_0000_0000_0000, // R4 write of 1 ignored
        16'b0000_0011_1011_0000, // R8 swi beats irq
        16'b0001_1000_0000_0000, // R9 restore of 1 cannot set flag
        16'b0001_0001_1111_0000, // R11 acceptance wins over return clear
        16'b1010_0100_1001_0000, // R11 acceptance wins over write
        16'b0000_0000_0001_0000, // R10 pulse lasts one cycle
        16'b0001_0000_0000_0000  // R9 return clears maskable flag
    };
    localparam int VREQ [NVEC] = '{2, 5, 2, 2, 7, 7, 8, 4, 4, 8, 9, 11, 11, 10, 9};

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic idle();
        irq_req = 1'b0; swi = 1'b0; trap = 1'b0;
        wr_en = 1'b0; wr_i = 1'b0; wr_x = 1'b0; rti = 1'b0; rti_x = 1'b0;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [15:0] v;
        string tag;
        idle();
        repeat (3) @(negedge clk);
        rst_ni = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1", "imask", int'(imask), 1);
        check("R1", "xmask", int'(xmask), 1);
        check("R1", "take", int'(take), 0);
        check("R1", "src", int'(src), 0);

        for (int k = 0; k < NVEC; k++) begin
            v = VEC[k];
            tag = $sformatf("R%0d vec%0d", VREQ[k], k);
            wr_en = v[15]; wr_i = v[14]; wr_x = v[13]; rti = v[12];
            rti_x = v[11]; trap = v[10]; swi = v[9]; irq_req = v[8];
            @(negedge clk);
            check(tag, "take", int'(take), int'(v[7]));
            if (v[7]) check(tag, "src", int'(src), int'(v[6:5]));
            check(tag, "imask", int'(imask), int'(v[4]));
            check(tag, "xmask", int'(xmask), int'(v[3]));
            idle();
        end

        // R3 pin latency with both flags clear
        xirq_n = 1'b0;
        for (int e = 1; e <= SYNC; e++) begin
            @(negedge clk);
            check("R3", "early take", int'(take), 0);
        end
        @(negedge clk);
        check("R3", "take", int'(take), 1);
        check("R3", "src", int'(src), 2);
        check("R6", "xmask set", int'(xmask), 1);
        check("R6", "imask set", int'(imask), 1);
        @(negedge clk);
        check("R3", "held pin blocked", int'(take), 0);
        xirq_n = 1'b1;
        repeat (SYNC + 1) @(negedge clk);
        rti = 1'b1; rti_x = 1'b0;
        @(negedge clk);
        idle();
        check("R9", "xmask restore 0", int'(xmask), 0);
        check("R9", "imask cleared", int'(imask), 0);

        // R8 pin beats maskable request
        xirq_n = 1'b0;
        repeat (SYNC) @(negedge clk);
        irq_req = 1'b1;
        @(negedge clk);
        check("R8", "take", int'(take), 1);
        check("R8", "src pin over irq", int'(src), 2);
        @(negedge clk);
        check("R2", "irq blocked after take", int'(take), 0);
        idle();
        xirq_n = 1'b1;
        repeat (SYNC + 1) @(negedge clk);

        // R1 reset sets the nonmaskable flag again, R3 pin then masked
        rst_ni = 1'b0;
        @(negedge clk);
        rst_ni = 1'b1;
        @(negedge clk);
        check("R1", "xmask after re-reset", int'(xmask), 1);
        check("R1", "imask after re-reset", int'(imask), 1);
        xirq_n = 1'b0;
        for (int c = 0; c < 5; c++) begin
            @(negedge clk);
            check("R3", "pin masked", int'(take), 0);
        end
        xirq_n = 1'b1;
        finish_run();
    end

endmodule